// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that completes one instruction in every clock cycle. In each cycle it reads the instruction word at the current program counter, reads two source registers and computes a result in the arithmetic unit. It then writes that result, or a word loaded from data memory, back to the register file. At the same clock edge it moves the program counter to the next instruction. It handles ten operations: five register-to-register operations (add, subtract, and, or, set-on-less-than), an add-immediate, a word load, a word store, a branch-if-equal and an unconditional jump.

The core has two memory ports. The first is an instruction port: a program-counter address goes out and a 32-bit word comes back. The second is a data port with address, write data, write strobe, read strobe and read data. Both memories sit outside the core and must answer within the same cycle. State changes only on the rising clock edge: the program counter, the register file and the data-memory write strobe. A synchronous, active-high reset sets the program counter to zero.

Instructions are 32 bits wide and come in three formats, with the opcode in bits 31:26. A register-format word carries the first source register in bits 25:21, the second source register in 20:16, the destination in 15:11, a shift field in 10:6 and a function code in 5:0. An immediate-format word keeps the opcode and both register fields and holds a 16-bit signed constant in 15:0. A jump-format word holds a 26-bit word target in 25:0.

Top module: `sc_core`

## Requirements
- R1: While reset is high at a clock edge, the program counter becomes 0, and `imem_addr` reads 0 after that edge.
- R2: Opcode 0x00 with shift field 0 selects a register operation by its function code: 0x20 adds, 0x22 subtracts (first minus second), 0x24 ands, 0x25 ors. The 32-bit result goes to the register named in bits 15:11.
- R3: Opcode 0x00 with function 0x2A writes 1 to the destination if the first source is less than the second as two's-complement values, and 0 otherwise.
- R4: Opcode 0x08 writes, to the register in bits 20:16, the first source plus the sign-extended 16-bit immediate.
- R5: Opcode 0x23 drives `dmem_re`=1 and `dmem_addr` = first source + sign-extended immediate, and in the same cycle writes `dmem_rdata` to the register in bits 20:16. `dmem_re` is 0 for every other instruction.
- R6: Opcode 0x2B drives `dmem_we`=1, the same address form as R5, and `dmem_wdata` = the register in bits 20:16. It writes no register. `dmem_we` is 0 for every other instruction.
- R7: Opcode 0x04 compares the two source registers. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. If not, the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to {PC+4 bits 31:28, the 26-bit target, 2'b00}.
- R9: Register 0 always reads as zero, and any write to it is dropped.
- R10: Any other opcode is a no-op, and so is a register-format word with an unlisted function code or a non-zero shift field: no register write, no memory strobe, PC advances by 4.
- R11: Every instruction except a branch or jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The bench runs every register operation over all pairs of six operands. The operands include zero, one, all-ones and both signed extremes. This exposes a set-on-less-than that compares unsigned values, which would invert the result whenever the signs differ, and a subtract with its operands swapped. Add-immediate is driven with 0x7FFF and 0x8000 to catch zero-extension of the immediate. A register-0 destination followed by a store of register 0 exposes a register file that keeps the write. Illegal words aimed at a live register, including one with a non-zero shift field, show whether the register gets corrupted. The branch cases are taken, not taken and a backward loop; a wrong offset shift or sign makes the fetch address diverge at once. A forward jump over a poisoned instruction checks the jump target splice.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;
  localparam int NREGS   = 1 << RIDX_W;
  localparam int IMM_W   = 16;
  localparam int JTGT_W  = 26;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    is_branch;
    logic    is_jump;
    logic    illegal;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.illegal = 1'b1;
        endcase
        if (shamt != 5'd0) ctrl.illegal = 1'b1;
        if (ctrl.illegal) begin
          ctrl.reg_we    = 1'b0;
          ctrl.dst_is_rd = 1'b0;
        end
      end
      OPC_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OPC_LDW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OPC_STW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OPC_JMP: ctrl.is_jump = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);

  logic [XLEN-1:0] store_q [NREG];

  // Single write port, no reset, so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store_q[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign eq = (a == b);

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   imm_ext,
  input  logic [JTGT_W-1:0] jtarget,
  input  logic              take_branch,
  input  logic              take_jump,
  output logic [XLEN-1:0]   pc_plus4,
  output logic [XLEN-1:0]   next_pc
);

  localparam int HI_W = XLEN - JTGT_W - 2;

  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  assign pc_plus4   = pc + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1 -: HI_W], jtarget, 2'b00};

  always_comb begin
    if (take_jump)        next_pc = jmp_target;
    else if (take_branch) next_pc = br_target;
    else                  next_pc = pc_plus4;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata
);

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_next;
  logic [XLEN-1:0]   pc_plus4;
  logic [5:0]        f_op;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
  logic [4:0]        f_sh;
  logic [5:0]        f_fn;
  logic [IMM_W-1:0]  f_imm;
  logic [XLEN-1:0]   imm_ext;
  ctrl_t             ctrl;
  logic [XLEN-1:0]   src_a, src_b, alu_b, alu_y;
  logic              src_eq;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata;

  assign f_op    = imem_rdata[31:26];
  assign f_rs    = imem_rdata[25:21];
  assign f_rt    = imem_rdata[20:16];
  assign f_rd    = imem_rdata[15:11];
  assign f_sh    = imem_rdata[10:6];
  assign f_fn    = imem_rdata[5:0];
  assign f_imm   = imem_rdata[15:0];
  assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

  sc_decode u_dec (
    .opcode (f_op),
    .shamt  (f_sh),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  sc_regfile #(.XLEN(XLEN), .NREG(NREGS)) u_rf (
    .clk     (clk),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (src_a),
    .rdata_b (src_b),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : src_b;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a  (src_a),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y),
    .eq (src_eq)
  );

  sc_nextpc #(.XLEN(XLEN)) u_npc (
    .pc          (pc_q),
    .imm_ext     (imm_ext),
    .jtarget     (imem_rdata[JTGT_W-1:0]),
    .take_branch (ctrl.is_branch && src_eq),
    .take_jump   (ctrl.is_jump),
    .pc_plus4    (pc_plus4),
    .next_pc     (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[XLEN-1:0];
    else     pc_q <= pc_next;
  end

  assign rf_we    = ctrl.reg_we;
  assign rf_waddr = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_wdata = ctrl.mem_rd ? dmem_rdata : alu_y;

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_we    = ctrl.mem_wr;
  assign dmem_re    = ctrl.mem_rd;

  // ---------------- assertions ----------------
  logic seen_edge_q;
  logic past_ok_q;
  always_ff @(posedge clk) begin
    seen_edge_q <= 1'b1;
    if (rst) past_ok_q <= 1'b0;
    else     past_ok_q <= 1'b1;
  end

  assert_pc_after_reset_R1: assert property (@(posedge clk)
    (seen_edge_q && $past(rst)) |-> (pc_q == RESET_PC[XLEN-1:0]));

  assert_seq_advance_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && $past(!ctrl.is_branch && !ctrl.is_jump))
      |-> (pc_q == $past(pc_q) + XLEN'(4)));

  assert_branch_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok_q && $past(ctrl.is_branch && src_eq))
      |-> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

  assert_store_no_rf_write_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |-> (!rf_we && !dmem_we && !dmem_re));

  assert_slt_boolean_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.reg_we && ctrl.alu_op == ALU_SLT) |-> (rf_wdata[XLEN-1:1] == '0));

endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam int MWORDS = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  always #5 clk = ~clk;

  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];
  logic [31:0] m_mem [MWORDS];
  logic [31:0] m_rf [32];
  string       m_tag [32];
  logic [31:0] m_pc;
  string       pc_tag;

  int n_checks = 0;
  int n_fail   = 0;
  int pw       = 0;
  int out_off  = 32'h200;
  bit finished = 0;

  assign imem_rdata = imem[imem_addr[11:2]];
  assign dmem_rdata = dmem[dmem_addr[11:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[11:2]] <= dmem_wdata;

  sc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn, int sh = 0);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word_target);
    return {6'h02, 26'(word_target)};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[pw] = w;
    pw++;
  endtask

  task automatic emit_store(input int rt);
    emit(enc_i(6'h2B, 0, rt, out_off));
    out_off += 4;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Reference step from the requirements: check ports for the instruction at m_pc, then update.
  task automatic model_step();
    logic [31:0] w, a, b, se, res;
    logic [5:0]  op, fn;
    int          rs, rt, rd, sh;
    bit          bad;
    w  = imem[m_pc[11:2]];
    op = w[31:26]; rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    sh = int'(w[10:6]); fn = w[5:0];
    se = {{16{w[15]}}, w[15:0]};
    a  = m_rf[rs]; b = m_rf[rt];
    bad = !(op inside {6'h00, 6'h02, 6'h04, 6'h08, 6'h23, 6'h2B}) ||
          (op == 6'h00 && (sh != 0 || !(fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A})));
    check(pc_tag, "imem_addr", imem_addr, m_pc);
    if (op == 6'h23) begin
      check("R5", "load strobe", {31'd0, dmem_re}, 32'd1);
      check("R5", "load address", dmem_addr, a + se);
      check("R5", "no store on load", {31'd0, dmem_we}, 32'd0);
    end else if (op == 6'h2B) begin
      check("R6", "store strobe", {31'd0, dmem_we}, 32'd1);
      check("R6", "store address", dmem_addr, a + se);
      check(m_tag[rt], "stored register value", dmem_wdata, b);
      check("R5", "no load strobe on store", {31'd0, dmem_re}, 32'd0);
    end else begin
      check(bad ? "R10" : "R6", "store strobe idle", {31'd0, dmem_we}, 32'd0);
      check(bad ? "R10" : "R5", "load strobe idle", {31'd0, dmem_re}, 32'd0);
    end
    pc_tag = "R11";
    if (bad) begin
      pc_tag = "R10";
      m_pc = m_pc + 4;
    end else begin
      case (op)
        6'h00: begin
          case (fn)
            6'h20:   res = a + b;
            6'h22:   res = a - b;
            6'h24:   res = a & b;
            6'h25:   res = a | b;
            default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          endcase
          if (rd != 0) begin
            m_rf[rd] = res;
            m_tag[rd] = (rs == 0 || rt == 0) ? "R9" : (fn == 6'h2A ? "R3" : "R2");
          end
          m_pc = m_pc + 4;
        end
        6'h08: begin
          if (rt != 0) begin m_rf[rt] = a + se; m_tag[rt] = "R4"; end
          m_pc = m_pc + 4;
        end
        6'h23: begin
          if (rt != 0) begin m_rf[rt] = m_mem[(a + se) >> 2]; m_tag[rt] = "R5"; end
          m_pc = m_pc + 4;
        end
        6'h2B: begin
          m_mem[(a + se) >> 2] = b;
          m_pc = m_pc + 4;
        end
        6'h04: begin
          pc_tag = "R7";
          m_pc = (a == b) ? (m_pc + 4 + (se << 2)) : (m_pc + 4);
        end
        default: begin
          pc_tag = "R8";
          m_pc = {m_pc[31:28] + 4'd0, w[25:0], 2'b00};
          m_pc[31:28] = (m_pc + 32'd0) >> 28;
        end
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin : main
    logic [31:0] vals [6];
    logic [5:0]  fns [5];
    int          imms [5];
    int          loop_top, halt_idx;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    imms[0] = 0; imms[1] = 1; imms[2] = -1; imms[3] = 32'h7FFF; imms[4] = 32'h8000;

    for (int k = 0; k < MWORDS; k++) begin
      imem[k] = 32'h0; dmem[k] = 32'h0; m_mem[k] = 32'h0;
    end
    for (int k = 0; k < 32; k++) begin m_rf[k] = 32'h0; m_tag[k] = "R9"; end
    for (int k = 0; k < 6; k++) begin dmem[k] = vals[k]; m_mem[k] = vals[k]; end

    // R2/R3: all operand pairs through every register operation
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        emit(enc_i(6'h23, 0, 1, 4 * i));
        emit(enc_i(6'h23, 0, 2, 4 * j));
        for (int f = 0; f < 5; f++) begin
          emit(enc_r(1, 2, 3, fns[f]));
          emit_store(3);
        end
      end
    end
    // R4: immediate sign extension
    emit(enc_i(6'h23, 0, 1, 20));
    for (int f = 0; f < 5; f++) begin
      emit(enc_i(6'h08, 1, 4, imms[f]));
      emit_store(4);
    end
    emit(enc_i(6'h08, 0, 9, -5));
    emit_store(9);
    // R9: writes to register 0 dropped, reads as zero
    emit(enc_i(6'h08, 0, 0, 7));
    emit_store(0);
    emit(enc_r(1, 1, 0, 6'h20));
    emit_store(0);
    emit(enc_r(0, 1, 5, 6'h20));
    emit_store(5);
    // R10: illegal words aimed at r6 leave it intact
    emit(enc_i(6'h08, 0, 6, 32'h55));
    emit(32'hFC06_1234);
    emit(enc_r(1, 1, 6, 6'h3F));
    emit(enc_r(1, 1, 6, 6'h20, 3));
    emit(enc_i(6'h3F, 0, 6, 0));
    emit_store(6);
    // R7: taken, not taken, backward loop
    emit(enc_i(6'h08, 0, 2, 3));
    emit(enc_i(6'h08, 0, 7, 1));
    emit(enc_i(6'h04, 1, 1, 1));
    emit(enc_i(6'h08, 0, 7, 99));
    emit_store(7);
    emit(enc_i(6'h04, 1, 2, 1));
    emit(enc_i(6'h08, 7, 7, 1));
    emit_store(7);
    emit(enc_i(6'h08, 0, 8, 3));
    loop_top = pw;
    emit(enc_i(6'h08, 8, 8, -1));
    emit(enc_i(6'h04, 8, 0, 1));
    emit(enc_i(6'h04, 0, 0, loop_top - (pw + 1)));
    emit_store(8);
    // R8: forward jump over a poisoned write, then halt loop
    emit(enc_j(pw + 2));
    emit(enc_i(6'h08, 0, 7, 123));
    emit_store(7);
    halt_idx = pw;
    emit(enc_j(halt_idx));

    // R1: reset
    rst = 1'b1;
    m_pc = 32'h0;
    pc_tag = "R11";
    repeat (3) @(negedge clk);
    check("R1", "imem_addr in reset", imem_addr, 32'h0);
    rst = 1'b0;
    check("R1", "first fetch address", imem_addr, 32'h0);

    for (int it = 0; it < 4000; it++) begin
      model_step();
      @(negedge clk);
      if (m_pc == 32'(4 * halt_idx) && pc_tag == "R8" && it > 10) break;
    end
    repeat (3) begin
      model_step();
      @(negedge clk);
    end
    finished = 1;
    summary();
  end

endmodule